// File: doc/BRIEF.md
# Power-Off Acknowledge Aggregation Controller

This block runs the power-off handshake of a packet switch that has one upstream port and a parameterised number of downstream ports. When the upstream side delivers a turn-off message, the block copies it to every downstream port that is active at that moment. It then collects one acknowledgement per port, or a per-port timeout that stands in for one. When all ports have answered, it issues a single acknowledgement upstream and asks for the upstream link to enter L2/L3 Ready. From the turn-off onward, power-management event generation is suppressed. It is allowed again only when the device is put into the D0 uninitialised state.

A packet that arrives upstream while the acknowledgements are still being gathered cancels the upstream acknowledgement. The downstream handshakes are left to finish. Once every port has acknowledged or timed out, the block orders every downstream link to retrain. A packet aimed at a downstream port is held in a one-entry buffer and released when that port's link reports L0. A packet aimed at the switch itself is passed to local handling at once. Once the upstream acknowledgement has been issued, late packets are dropped. Link training, packet decoding and configuration storage sit outside the block and appear only as strobes and status levels.

Top module: `pwroff_ack_agg`

## Requirements
- R1: After reset every output is 0, and power-event blocking is off.
- R2: A turn-off strobe received while idle produces, one cycle later, a one-cycle `dn_turnoff_o` pulse equal to the `dn_active_i` value sampled with the strobe. `pme_block_o` rises in the same cycle.
- R3: `up_ack_o` and `up_l2l3_req_o` pulse together for one cycle, on the clock edge after the one at which the last outstanding port became acknowledged. A port that is inactive at broadcast counts as already acknowledged, so with no active ports the pulse comes on the second edge after the turn-off strobe.
- R4: With a nonzero timeout value T, a port that has not acknowledged times out on the T-th edge after the turn-off edge. At that edge it becomes acknowledged, and bit i of `dn_l2l3_req_o` pulses for one cycle. An acknowledgement sampled before that edge prevents the timeout.
- R5: A timeout value of 0 disables the timer, so an unacknowledged port waits indefinitely.
- R6: A packet strobe sampled while acknowledgements are being gathered abandons the aggregation. This includes the cycle in which the last acknowledgement has just been recorded. After an abandon no upstream acknowledgement is sent, and downstream acknowledgements are still collected.
- R7: After an abandon, once every port is acknowledged or timed out, `dn_retrain_o` pulses all ones for one cycle. The timing is the same as for `up_ack_o` in R3.
- R8: A held packet for downstream port d is released with a one-cycle `fwd_valid_o` and `fwd_dest_o` = d. The release happens at the first edge after the retrain pulse at which `dn_link_l0_i[d]` is 1, and never while that link is out of L0.
- R9: An abandoning packet with `up_pkt_to_sw_i` = 1 produces a one-cycle `local_pkt_o` on the next edge. No forward follows the retrain.
- R10: After `up_ack_o` has been issued, a packet strobe produces a one-cycle `pkt_drop_o` and causes no abandon or retrain.
- R11: `pme_block_o` stays at 1 until a `d0_uninit_i` strobe clears it on the next edge. That strobe also returns a finished handshake to idle, so a new turn-off is accepted.
- R12: Acknowledge bits are sticky within one handshake and are all rebuilt at each new turn-off. An acknowledgement from an earlier handshake does not count toward a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_turnoff_i | input | 1 | Turn-off message received upstream (strobe) |
| up_pkt_valid_i | input | 1 | Packet received upstream (strobe) |
| up_pkt_to_sw_i | input | 1 | Packet targets the switch itself |
| up_pkt_dest_i | input | IDX_W | Downstream port targeted by the packet |
| dn_active_i | input | NUM_DN | Downstream port is active |
| dn_ack_i | input | NUM_DN | Acknowledge received on downstream port (strobe) |
| dn_link_l0_i | input | NUM_DN | Downstream link is in L0 |
| ack_tmo_val_i | input | TMR_W | Timeout in cycles, 0 disables |
| d0_uninit_i | input | 1 | Device placed into D0 uninitialised (strobe) |
| dn_turnoff_o | output | NUM_DN | Forward turn-off per port (pulse) |
| dn_l2l3_req_o | output | NUM_DN | Timed-out port must enter L2/L3 Ready (pulse) |
| dn_retrain_o | output | NUM_DN | Retrain link through Detect to L0 (pulse) |
| up_ack_o | output | 1 | Send acknowledge upstream (pulse) |
| up_l2l3_req_o | output | 1 | Upstream link to L2/L3 Ready (pulse) |
| pme_block_o | output | 1 | Power-management event generation blocked |
| local_pkt_o | output | 1 | Abandoning packet handled by the switch (pulse) |
| fwd_valid_o | output | 1 | Held packet forwarded (pulse) |
| fwd_dest_o | output | IDX_W | Destination of the forwarded packet |
| pkt_drop_o | output | 1 | Late packet discarded (pulse) |

## Verification
The assertions check the following on every cycle:
- a turn-off is never forwarded to a port that was inactive;
- the upstream acknowledgement and the retrain pulse follow only a full set of acknowledge bits;
- a forward happens only while the target link reports L0;
- acknowledge bits never clear except at a new turn-off;
- the timeout counters never count upward;
- the packet buffer is never overwritten.

The exact cycles need the bench's scenarios. These cover the sweep over every active-port mask, the timeout lengths, and the abandon that lands in the same cycle as the last acknowledgement. The same holds for the sequence of retrain, wait for L0 and forward, the drop after completion, and the release of power-event blocking.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
   typedef enum logic [2:0] {
      AGG_IDLE = 3'd0,
      AGG_WAIT = 3'd1,
      AGG_ABND = 3'd2,
      AGG_RETR = 3'd3,
      AGG_DONE = 3'd4
   } agg_state_e;
endpackage

// File: rtl/pwroff_ack_timer.sv
module pwroff_ack_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] tmo_val_i,
   input  logic             ack_i,
   input  logic             pending_i,
   output logic             expire_o
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   logic [TMR_W-1:0] cnt_q;

   assign expire_o = pending_i && !ack_i && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= tmo_val_i;
      else if (ack_i || expire_o)      cnt_q <= '0;
      else if (pending_i && cnt_q > ONE) cnt_q <= cnt_q - ONE;
   end

   AST_TMR_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (cnt_q <= $past(cnt_q))); // R4
endmodule

// File: rtl/pwroff_ack_tracker.sv
module pwroff_ack_tracker #(
   parameter int NUM_DN = 4,
   parameter int TMR_W  = 16,
   parameter bit TMO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NUM_DN-1:0] active_i,
   input  logic              waiting_i,
   input  logic [NUM_DN-1:0] ack_i,
   input  logic [TMR_W-1:0]  tmo_val_i,
   output logic              all_acked_o,
   output logic [NUM_DN-1:0] l2l3_req_o
);
   logic [NUM_DN-1:0] ackd_q;
   logic [NUM_DN-1:0] expire;
   logic [NUM_DN-1:0] ack_live;
   logic [NUM_DN-1:0] pending;

   assign ack_live = ack_i & {NUM_DN{waiting_i}};
   assign pending  = ~ackd_q & {NUM_DN{waiting_i}};

   for (genvar i = 0; i < NUM_DN; i++) begin : g_port
      if (TMO_EN) begin : g_tmr
         pwroff_ack_timer #(.TMR_W(TMR_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (start_i),
            .tmo_val_i (tmo_val_i),
            .ack_i     (ack_live[i]),
            .pending_i (pending[i]),
            .expire_o  (expire[i])
         );
      end else begin : g_notmr
         assign expire[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ackd_q     <= '0;
         l2l3_req_o <= '0;
      end else if (start_i) begin
         ackd_q     <= ~active_i;
         l2l3_req_o <= '0;
      end else begin
         ackd_q     <= ackd_q | ack_live | expire;
         l2l3_req_o <= expire;
      end
   end

   assign all_acked_o = &ackd_q;

   AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ((ackd_q & $past(ackd_q)) == $past(ackd_q))); // R12
   AST_TMO_IS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((l2l3_req_o & ~ackd_q) == '0)); // R4
endmodule

// File: rtl/pwroff_pkt_hold.sv
module pwroff_pkt_hold #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] dest_i,
   input  logic             take_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] dest_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         dest_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         dest_o  <= dest_i;
      end else if (take_i) begin
         valid_o <= 1'b0;
      end
   end

   AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !valid_o); // R8
   AST_HOLD_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> valid_o); // R8
endmodule

// File: rtl/pwroff_ack_agg.sv
module pwroff_ack_agg
   import pwroff_pkg::*;
#(
   parameter int NUM_DN = 4,
   parameter int TMR_W  = 16,
   parameter bit TMO_EN = 1'b1,
   localparam int IDX_W = (NUM_DN > 1) ? $clog2(NUM_DN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_turnoff_i,
   input  logic              up_pkt_valid_i,
   input  logic              up_pkt_to_sw_i,
   input  logic [IDX_W-1:0]  up_pkt_dest_i,
   input  logic [NUM_DN-1:0] dn_active_i,
   input  logic [NUM_DN-1:0] dn_ack_i,
   input  logic [NUM_DN-1:0] dn_link_l0_i,
   input  logic [TMR_W-1:0]  ack_tmo_val_i,
   input  logic              d0_uninit_i,
   output logic [NUM_DN-1:0] dn_turnoff_o,
   output logic [NUM_DN-1:0] dn_l2l3_req_o,
   output logic [NUM_DN-1:0] dn_retrain_o,
   output logic              up_ack_o,
   output logic              up_l2l3_req_o,
   output logic              pme_block_o,
   output logic              local_pkt_o,
   output logic              fwd_valid_o,
   output logic [IDX_W-1:0]  fwd_dest_o,
   output logic              pkt_drop_o
);
   if (NUM_DN < 2)  begin : g_chk_ports $error("NUM_DN must be at least 2"); end
   if (TMR_W < 2)   begin : g_chk_tmr   $error("TMR_W must be at least 2"); end

   agg_state_e       state_q;
   logic             start, waiting, abandon, all_acked;
   logic             buf_valid, buf_load, take, dest_l0;
   logic [IDX_W-1:0] buf_dest;

   assign start   = (state_q == AGG_IDLE) && up_turnoff_i;
   assign waiting = (state_q == AGG_WAIT) || (state_q == AGG_ABND);
   assign abandon = (state_q == AGG_WAIT) && up_pkt_valid_i;
   assign buf_load = abandon && !up_pkt_to_sw_i;

   always_comb begin
      dest_l0 = 1'b0;
      for (int i = 0; i < NUM_DN; i++)
         if (buf_dest == IDX_W'(i)) dest_l0 = dn_link_l0_i[i];
   end

   assign take = (state_q == AGG_RETR) && buf_valid && dest_l0;

   pwroff_ack_tracker #(.NUM_DN(NUM_DN), .TMR_W(TMR_W), .TMO_EN(TMO_EN)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .active_i    (dn_active_i),
      .waiting_i   (waiting),
      .ack_i       (dn_ack_i),
      .tmo_val_i   (ack_tmo_val_i),
      .all_acked_o (all_acked),
      .l2l3_req_o  (dn_l2l3_req_o)
   );

   pwroff_pkt_hold #(.IDX_W(IDX_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (buf_load),
      .dest_i  (up_pkt_dest_i),
      .take_i  (take),
      .valid_o (buf_valid),
      .dest_o  (buf_dest)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= AGG_IDLE;
         dn_turnoff_o  <= '0;
         dn_retrain_o  <= '0;
         up_ack_o      <= 1'b0;
         up_l2l3_req_o <= 1'b0;
         pme_block_o   <= 1'b0;
         local_pkt_o   <= 1'b0;
         fwd_valid_o   <= 1'b0;
         fwd_dest_o    <= '0;
         pkt_drop_o    <= 1'b0;
      end else begin
         dn_turnoff_o  <= '0;
         dn_retrain_o  <= '0;
         up_ack_o      <= 1'b0;
         up_l2l3_req_o <= 1'b0;
         local_pkt_o   <= 1'b0;
         fwd_valid_o   <= 1'b0;
         pkt_drop_o    <= 1'b0;

         if (start)            pme_block_o <= 1'b1;
         else if (d0_uninit_i) pme_block_o <= 1'b0;

         unique case (state_q)
            AGG_IDLE: begin
               if (up_turnoff_i) begin
                  dn_turnoff_o <= dn_active_i;
                  state_q      <= AGG_WAIT;
               end
            end
            AGG_WAIT: begin
               if (up_pkt_valid_i) begin
                  local_pkt_o <= up_pkt_to_sw_i;
                  state_q     <= AGG_ABND;
               end else if (all_acked) begin
                  up_ack_o      <= 1'b1;
                  up_l2l3_req_o <= 1'b1;
                  state_q       <= AGG_DONE;
               end
            end
            AGG_ABND: begin
               if (all_acked) begin
                  dn_retrain_o <= '1;
                  state_q      <= AGG_RETR;
               end
            end
            AGG_RETR: begin
               if (!buf_valid) begin
                  state_q <= AGG_IDLE;
               end else if (dest_l0) begin
                  fwd_valid_o <= 1'b1;
                  fwd_dest_o  <= buf_dest;
                  state_q     <= AGG_IDLE;
               end
            end
            AGG_DONE: begin
               pkt_drop_o <= up_pkt_valid_i;
               if (d0_uninit_i) state_q <= AGG_IDLE;
            end
            default: state_q <= AGG_IDLE;
         endcase
      end
   end

   AST_TURNOFF_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_turnoff_o & ~$past(dn_active_i)) == '0)); // R2
   AST_PME_BLOCK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pme_block_o) |-> $past(up_turnoff_i)); // R2
   AST_UP_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      up_ack_o |-> $past(all_acked)); // R3
   AST_UP_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      up_ack_o |=> !up_ack_o); // R3
   AST_RETRAIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (|dn_retrain_o) |-> $past(all_acked)); // R7
   AST_FWD_IN_L0: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid_o |-> $past(dest_l0)); // R8
   AST_NO_ACK_AFTER_ABND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AGG_ABND) |-> !up_ack_o); // R6
endmodule

// File: tb/pwroff_ack_agg_tb.sv
module pwroff_ack_agg_tb;
   localparam int N  = 4;
   localparam int TW = 8;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_turnoff_i = 1'b0, up_pkt_valid_i = 1'b0, up_pkt_to_sw_i = 1'b0;
   logic [IW-1:0] up_pkt_dest_i = '0;
   logic [N-1:0]  dn_active_i = '0, dn_ack_i = '0, dn_link_l0_i = '0;
   logic [TW-1:0] ack_tmo_val_i = '0;
   logic          d0_uninit_i = 1'b0;
   logic [N-1:0]  dn_turnoff_o, dn_l2l3_req_o, dn_retrain_o;
   logic          up_ack_o, up_l2l3_req_o, pme_block_o, local_pkt_o, fwd_valid_o, pkt_drop_o;
   logic [IW-1:0] fwd_dest_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pwroff_ack_agg #(.NUM_DN(N), .TMR_W(TW)) u_dut (.*);

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic back_to_idle();
      d0_uninit_i = 1'b1;
      tick();
      d0_uninit_i = 1'b0;
      chk("R11", "pme_block after d0", int'(pme_block_o), 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      chk("R1", "outputs after reset",
          int'({dn_turnoff_o, dn_l2l3_req_o, dn_retrain_o, up_ack_o, up_l2l3_req_o,
                pme_block_o, local_pkt_o, fwd_valid_o, fwd_dest_o, pkt_drop_o}), 0);

      // R2/R3: sweep every active mask with acks one per cycle, timer off
      for (int m = 0; m < (1 << N); m++) begin
         dn_active_i  = N'(m);
         up_turnoff_i = 1'b1;
         tick();
         up_turnoff_i = 1'b0;
         chk("R2", "turnoff fanout", int'(dn_turnoff_o), m);
         chk("R2", "pme_block set", int'(pme_block_o), 1);
         for (int p = 0; p < N; p++) begin
            if (m[p]) begin
               chk("R3", "no early up ack", int'(up_ack_o), 0);
               dn_ack_i = N'(1 << p);
               tick();
               dn_ack_i = '0;
            end
         end
         tick();
         chk("R3", "up ack after last", int'({up_ack_o, up_l2l3_req_o}), 3);
         tick();
         chk("R3", "up ack one cycle", int'(up_ack_o), 0);
         chk("R11", "pme_block held", int'(pme_block_o), 1);
         back_to_idle();
      end

      // R12: a fresh handshake needs fresh acks
      dn_active_i  = 4'b0010;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      repeat (5) tick();
      chk("R12", "no ack carried over", int'(up_ack_o), 0);
      dn_ack_i = 4'b0010; tick(); dn_ack_i = '0; tick();
      chk("R12", "ack after fresh ack", int'(up_ack_o), 1);
      back_to_idle();

      // R4: timeout lengths 1..6, single active port, no ack
      for (int t = 1; t <= 6; t++) begin
         ack_tmo_val_i = TW'(t);
         dn_active_i   = 4'b0100;
         up_turnoff_i  = 1'b1;
         tick();
         up_turnoff_i  = 1'b0;
         for (int k = 1; k < t; k++) begin
            tick();
            chk("R4", "no early timeout", int'(dn_l2l3_req_o), 0);
         end
         tick();
         chk("R4", "timeout at edge T", int'(dn_l2l3_req_o), 4);
         tick();
         chk("R4", "timeout counts as ack", int'(up_ack_o), 1);
         chk("R4", "l2l3 one cycle", int'(dn_l2l3_req_o), 0);
         back_to_idle();
      end

      // R4: ack before the deadline suppresses the timeout
      ack_tmo_val_i = 8'd4;
      dn_active_i   = 4'b0001;
      up_turnoff_i  = 1'b1;
      tick();
      up_turnoff_i  = 1'b0;
      tick(); tick();
      dn_ack_i = 4'b0001; tick(); dn_ack_i = '0;
      chk("R4", "no l2l3 with ack", int'(dn_l2l3_req_o), 0);
      tick();
      chk("R4", "ack path", int'({up_ack_o, dn_l2l3_req_o}), 16);
      back_to_idle();

      // R5: zero disables the timer
      ack_tmo_val_i = '0;
      dn_active_i   = 4'b1000;
      up_turnoff_i  = 1'b1;
      tick();
      up_turnoff_i  = 1'b0;
      repeat (40) tick();
      chk("R5", "no timeout when zero", int'({up_ack_o, dn_l2l3_req_o}), 0);
      dn_ack_i = 4'b1000; tick(); dn_ack_i = '0; tick();
      chk("R5", "ack still completes", int'(up_ack_o), 1);
      back_to_idle();

      // R6/R7/R8: abandon toward port 1, acks keep coming
      dn_active_i  = 4'b0011;
      dn_link_l0_i = '0;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      dn_ack_i = 4'b0001; tick(); dn_ack_i = '0;
      up_pkt_valid_i = 1'b1; up_pkt_dest_i = 2'd1; up_pkt_to_sw_i = 1'b0;
      tick();
      up_pkt_valid_i = 1'b0;
      chk("R9", "no local for port pkt", int'(local_pkt_o), 0);
      dn_ack_i = 4'b0010; tick(); dn_ack_i = '0;
      chk("R6", "no up ack after abandon", int'(up_ack_o), 0);
      tick();
      chk("R7", "retrain all ports", int'(dn_retrain_o), 15);
      chk("R6", "still no up ack", int'(up_ack_o), 0);
      tick(); tick();
      chk("R8", "wait while link down", int'(fwd_valid_o), 0);
      dn_link_l0_i = 4'b0010;
      tick();
      chk("R8", "forward on L0", int'({fwd_valid_o, fwd_dest_o}), 5);
      tick();
      chk("R8", "forward one cycle", int'(fwd_valid_o), 0);
      dn_link_l0_i = '0;
      back_to_idle();

      // R6: packet in the same cycle the last ack is recorded still abandons
      dn_active_i  = 4'b0001;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      dn_ack_i = 4'b0001; tick(); dn_ack_i = '0;
      up_pkt_valid_i = 1'b1; up_pkt_dest_i = 2'd3;
      tick();
      up_pkt_valid_i = 1'b0;
      chk("R6", "race: no up ack", int'(up_ack_o), 0);
      tick();
      chk("R7", "race: retrain", int'(dn_retrain_o), 15);
      dn_link_l0_i = 4'b1000;
      tick();
      chk("R8", "race: forward port 3", int'({fwd_valid_o, fwd_dest_o}), 7);
      dn_link_l0_i = '0;
      back_to_idle();

      // R9: packet for the switch itself
      dn_active_i  = 4'b0001;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      up_pkt_valid_i = 1'b1; up_pkt_to_sw_i = 1'b1;
      tick();
      up_pkt_valid_i = 1'b0; up_pkt_to_sw_i = 1'b0;
      chk("R9", "local handling", int'(local_pkt_o), 1);
      dn_ack_i = 4'b0001; tick(); dn_ack_i = '0;
      chk("R9", "local one cycle", int'(local_pkt_o), 0);
      tick();
      chk("R7", "retrain after local", int'(dn_retrain_o), 15);
      dn_link_l0_i = '1;
      tick();
      chk("R9", "no forward", int'(fwd_valid_o), 0);
      tick();
      chk("R9", "no forward later", int'(fwd_valid_o), 0);
      dn_link_l0_i = '0;
      back_to_idle();

      // R10: late packet after the upstream ack
      dn_active_i  = 4'b0001;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      dn_ack_i = 4'b0001; tick(); dn_ack_i = '0;
      tick();
      chk("R10", "up ack sent", int'(up_ack_o), 1);
      up_pkt_valid_i = 1'b1;
      tick();
      up_pkt_valid_i = 1'b0;
      chk("R10", "packet dropped", int'(pkt_drop_o), 1);
      tick();
      chk("R10", "no retrain after drop", int'({dn_retrain_o, local_pkt_o, pkt_drop_o}), 0);
      back_to_idle();

      // R11: after d0 a new turn-off is accepted
      dn_active_i  = 4'b0110;
      up_turnoff_i = 1'b1;
      tick();
      up_turnoff_i = 1'b0;
      chk("R11", "new turnoff accepted", int'(dn_turnoff_o), 6);
      chk("R11", "block again", int'(pme_block_o), 1);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule